// File: doc/BRIEF.md
# Dual-Form Maximal-Length Pseudorandom Sequence Generator

This block is a 16-bit linear feedback shift register that produces a maximal-length pseudorandom sequence. It uses the primitive polynomial x^16+x^14+x^13+x^11+1. A mode input, held static while the generator runs, picks how the next state is formed:

- **External-XOR form:** several state bits are combined into a single feedback bit.
- **Internal-XOR form:** the output bit toggles a fixed set of positions as the register shifts.

Both forms step through every nonzero 16-bit value before they repeat.

Software or a neighbouring block loads a seed with a one-cycle strobe. It then raises the advance enable for each step it wants. The full state is available on a parallel output, and the rightmost state bit is available as a serial stream. A seed of zero is replaced with one, so the register can never stall in the all-zero state. A one-cycle flag marks the step on which the state returns to the most recently loaded seed, which is the end of a full period.

Top module: `prsg_dual16`

## Requirements
- R1: While reset is high and on the first cycle after it, the state output reads 0x0001 and the wrap flag is low.
- R2: A load strobe puts the seed on the state output in the next cycle, even when the advance enable is high in the same cycle.
- R3: A loaded seed of 0x0000 is replaced by 0x0001.
- R4: With load and advance both low, the state output holds its value and the wrap flag stays low.
- R5: With mode 0 (external-XOR) and an advance, the next state is the current state shifted right by one. Bit 15 receives the XOR of current bits 0, 2, 3 and 5. State 0xACE1 is followed by 0x5670.
- R6: With mode 1 (internal-XOR) and an advance, the next state is the current state shifted right by one. If current bit 0 was 1, the shifted value is XORed with 0xB400. State 0xACE1 is followed by 0xE270.
- R7: The serial output always equals bit 0 of the state output.
- R8: In either mode, starting from a loaded seed, the state first returns to that seed after exactly 65535 advances. The wrap flag is high for exactly that one cycle.
- R9: The state output is never 0x0000 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Seed load strobe, takes priority over advance |
| seed_i | input | 16 | Seed value captured on load |
| adv_i | input | 1 | Advance enable, one step per cycle while high |
| mode_i | input | 1 | 0 = external-XOR form, 1 = internal-XOR form; static while running |
| state_o | output | 16 | Current register state |
| serial_o | output | 1 | Serial output, bit 0 of the state |
| wrap_o | output | 1 | One-cycle pulse when an advance returns the state to the loaded seed |

## Verification
Every result is registered. A load, advance or hold sampled at one rising edge shows on the state, serial and wrap outputs just after that same edge, and stays there until the next edge. The bench drives inputs on the falling edge and samples one time unit after the rising edge. On every cycle it compares all three outputs against a behavioural model that it advances in the same step. Two full 65535-step periods, one per mode, confirm that the wrap pulse lands on the last step and nowhere else.

// File: rtl/prsg_pkg.sv
package prsg_pkg;
   localparam int unsigned PRSG_W = 16;

   typedef enum logic {
      PRSG_MODE_EXT = 1'b0,
      PRSG_MODE_INT = 1'b1
   } prsg_mode_e;

   localparam logic [PRSG_W-1:0] PRSG_EXT_TAPS   = 16'h002D;
   localparam logic [PRSG_W-1:0] PRSG_INT_TOGGLE = 16'hB400;
   localparam logic [PRSG_W-1:0] PRSG_FALLBACK   = 16'h0001;
endpackage

// File: rtl/prsg_ext_next.sv
module prsg_ext_next #(
   parameter int unsigned        WIDTH = 16,
   parameter logic [WIDTH-1:0]   TAPS  = 16'h002D
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o
);
   logic feedback;

   initial begin
      if (TAPS[0] != 1'b1) $error("external form: bit 0 must be a tap");
   end

   assign feedback = ^(cur_i & TAPS);
   assign nxt_o    = {feedback, cur_i[WIDTH-1:1]};
endmodule

// File: rtl/prsg_int_next.sv
module prsg_int_next #(
   parameter int unsigned        WIDTH  = 16,
   parameter logic [WIDTH-1:0]   TOGGLE = 16'hB400
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o
);
   initial begin
      if (TOGGLE[WIDTH-1] != 1'b1) $error("internal form: top bit must toggle");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == WIDTH-1) begin : g_top
         assign nxt_o[i] = cur_i[0];
      end else if (TOGGLE[i]) begin : g_tap
         assign nxt_o[i] = cur_i[i+1] ^ cur_i[0];
      end else begin : g_pass
         assign nxt_o[i] = cur_i[i+1];
      end
   end
endmodule

// File: rtl/prsg_seed_guard.sv
module prsg_seed_guard #(
   parameter int unsigned        WIDTH    = 16,
   parameter logic [WIDTH-1:0]   FALLBACK = 16'h0001
) (
   input  logic [WIDTH-1:0] seed_i,
   output logic [WIDTH-1:0] seed_o
);
   initial begin
      if (FALLBACK == '0) $error("fallback seed must be nonzero");
   end

   assign seed_o = (seed_i == '0) ? FALLBACK : seed_i;
endmodule

// File: rtl/prsg_dual16.sv
module prsg_dual16
   import prsg_pkg::*;
#(
   parameter int unsigned        WIDTH       = PRSG_W,
   parameter logic [WIDTH-1:0]   EXT_TAPS    = PRSG_EXT_TAPS,
   parameter logic [WIDTH-1:0]   INT_TOGGLE  = PRSG_INT_TOGGLE,
   parameter logic [WIDTH-1:0]   RESET_STATE = PRSG_FALLBACK
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [WIDTH-1:0]  seed_i,
   input  logic              adv_i,
   input  logic              mode_i,
   output logic [WIDTH-1:0]  state_o,
   output logic              serial_o,
   output logic              wrap_o
);
   localparam logic [WIDTH-1:0] ZERO = '0;

   initial begin
      if (WIDTH < 2)            $error("WIDTH must be at least 2");
      if (RESET_STATE == ZERO)  $error("reset state must be nonzero");
   end

   prsg_mode_e       mode;
   logic [WIDTH-1:0] state_q, seed_q;
   logic [WIDTH-1:0] ext_nxt, int_nxt, step_nxt, seed_safe;
   logic             wrap_q;

   assign mode = prsg_mode_e'(mode_i);

   prsg_ext_next #(.WIDTH(WIDTH), .TAPS(EXT_TAPS)) u_ext (
      .cur_i (state_q),
      .nxt_o (ext_nxt)
   );

   prsg_int_next #(.WIDTH(WIDTH), .TOGGLE(INT_TOGGLE)) u_int (
      .cur_i (state_q),
      .nxt_o (int_nxt)
   );

   prsg_seed_guard #(.WIDTH(WIDTH), .FALLBACK(RESET_STATE)) u_guard (
      .seed_i (seed_i),
      .seed_o (seed_safe)
   );

   always_comb begin
      unique case (mode)
         PRSG_MODE_INT: step_nxt = int_nxt;
         default:       step_nxt = ext_nxt;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= RESET_STATE;
         seed_q  <= RESET_STATE;
         wrap_q  <= 1'b0;
      end else if (load_i) begin
         state_q <= seed_safe;
         seed_q  <= seed_safe;
         wrap_q  <= 1'b0;
      end else if (adv_i) begin
         state_q <= step_nxt;
         wrap_q  <= (step_nxt == seed_q);
      end else begin
         wrap_q  <= 1'b0;
      end
   end

   assign state_o  = state_q;
   assign serial_o = state_q[0];
   assign wrap_o   = wrap_q;

   AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> state_q == (($past(seed_i) == ZERO) ? RESET_STATE : $past(seed_i))); // R2
   AST_ZERO_SEED: assert property (@(posedge clk_i) disable iff (rst_i)
      (load_i && seed_i == ZERO) |=> state_q == RESET_STATE); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && !adv_i) |=> ($stable(state_q) && !wrap_o)); // R4
   AST_EXT_SHIFT: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && adv_i && mode_i == 1'b0) |=> state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1])); // R5
   AST_INT_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && adv_i && mode_i == 1'b1) |=> state_q[WIDTH-1] == $past(state_q[0])); // R6
   AST_WRAP_AT_SEED: assert property (@(posedge clk_i) disable iff (rst_i)
      wrap_o |-> (state_q == seed_q)); // R8
   AST_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q != ZERO); // R9
endmodule

// File: tb/prsg_dual16_bench.sv
module prsg_dual16_bench;
   logic        clk = 1'b0;
   logic        rst_i = 1'b1;
   logic        load_i = 1'b0;
   logic [15:0] seed_i = 16'h0000;
   logic        adv_i = 1'b0;
   logic        mode_i = 1'b0;
   logic [15:0] state_o;
   logic        serial_o;
   logic        wrap_o;

   int unsigned vectors = 0;
   int unsigned fails = 0;
   bit          finished = 1'b0;

   logic [15:0] m_state = 16'h0001;
   logic [15:0] m_seed  = 16'h0001;
   logic        m_wrap  = 1'b0;
   int unsigned wrap_count;
   int unsigned wrap_step;

   always #10 clk = ~clk;

   prsg_dual16 u_prsg_dual16 (
      .clk_i   (clk),
      .rst_i   (rst_i),
      .load_i  (load_i),
      .seed_i  (seed_i),
      .adv_i   (adv_i),
      .mode_i  (mode_i),
      .state_o (state_o),
      .serial_o(serial_o),
      .wrap_o  (wrap_o)
   );

   function automatic logic [15:0] ref_step(input logic [15:0] s, input logic md);
      logic [15:0] n;
      if (md == 1'b0) begin
         n = {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
      end else begin
         n = s >> 1;
         if (s[0]) n = n ^ 16'hB400;
      end
      return n;
   endfunction

   task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // one clock: drive at falling edge, update model, sample after rising edge
   task automatic cyc(input logic ld, input logic [15:0] sd, input logic ad);
      logic [15:0] nxt;
      @(negedge clk);
      load_i = ld; seed_i = sd; adv_i = ad;
      @(posedge clk);
      if (ld) begin
         m_state = (sd == 16'h0000) ? 16'h0001 : sd;
         m_seed  = m_state;
         m_wrap  = 1'b0;
      end else if (ad) begin
         nxt     = ref_step(m_state, mode_i);
         m_state = nxt;
         m_wrap  = (nxt == m_seed);
      end else begin
         m_wrap  = 1'b0;
      end
      #1;
      check16("R5/R6 state vs model", state_o, m_state);
      check1("R7 serial bit", serial_o, state_o[0]);
      check1("R8 wrap flag vs model", wrap_o, m_wrap);
      check1("R9 nonzero state", state_o != 16'h0000, 1'b1);
   endtask

   task automatic full_period(input logic [15:0] sd, input string req);
      cyc(1'b1, sd, 1'b0);
      wrap_count = 0;
      wrap_step  = 0;
      for (int k = 1; k <= 65535; k++) begin
         cyc(1'b0, 16'h0000, 1'b1);
         if (wrap_o) begin
            wrap_count++;
            if (wrap_step == 0) wrap_step = k;
         end
      end
      check16({req, " wrap pulses"}, wrap_count[15:0], 16'd1);
      check16({req, " period length"}, wrap_step[15:0], 16'hFFFF);
      check16({req, " back at seed"}, state_o, sd);
      cyc(1'b0, 16'h0000, 1'b0);
      check1({req, " wrap one cycle"}, wrap_o, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check16("R1 reset state", state_o, 16'h0001);
      check1("R1 reset wrap", wrap_o, 1'b0);
      @(negedge clk);
      rst_i = 1'b0;
      @(posedge clk);
      #1;
      check16("R1 state after reset", state_o, 16'h0001);
      check1("R1 wrap after reset", wrap_o, 1'b0);

      // external-XOR form
      mode_i = 1'b0;
      cyc(1'b1, 16'hACE1, 1'b0);
      check16("R2 load", state_o, 16'hACE1);
      cyc(1'b0, 16'h0000, 1'b1);
      check16("R5 ACE1 step", state_o, 16'h5670);
      for (int k = 0; k < 4; k++) begin
         cyc(1'b0, 16'hFFFF, 1'b0);
         check16("R4 hold", state_o, 16'h5670);
         check1("R4 hold wrap", wrap_o, 1'b0);
      end
      cyc(1'b1, 16'h1234, 1'b1);
      check16("R2 load over advance", state_o, 16'h1234);
      cyc(1'b1, 16'h0000, 1'b1);
      check16("R3 zero seed", state_o, 16'h0001);
      for (int k = 0; k < 40; k++) cyc(1'b0, 16'h0000, (k % 3) != 0);
      full_period(16'h0001, "R8 ext");

      // internal-XOR form
      mode_i = 1'b1;
      cyc(1'b1, 16'hACE1, 1'b0);
      cyc(1'b0, 16'h0000, 1'b1);
      check16("R6 ACE1 step", state_o, 16'hE270);
      for (int k = 0; k < 40; k++) cyc(1'b0, 16'h0000, (k % 2) == 0);
      cyc(1'b0, 16'h0000, 1'b0);
      check16("R4 hold int", state_o, m_state);
      cyc(1'b1, 16'h0000, 1'b0);
      check16("R3 zero seed int", state_o, 16'h0001);
      full_period(16'hBEEF, "R8 int");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule